// File: doc/BRIEF.md
# Prioritized Interrupt Controller with Wake-Up Lines

This block sits beside a small 32-bit processor core and decides which of eight interrupt request lines is served next. Each line is watched for a rising edge. An edge on an enabled normal line is held as pending until it is dispatched. An edge on an enabled line marked for wake-up only produces a short wake pulse. A configuration write port loads one control word, which holds an enable mask and a wake-up mask, and eight handler addresses. The core takes interrupts through a valid/ready handshake. Each offer carries the line number and that line's handler address. The core reports the end of a handler with a return pulse.

The dispatch machine has three states. In `DS_IDLE` it looks for pending work. In `DS_OFFER` it presents one request and holds it until the core accepts it. In `DS_BUSY` a handler is running and dispatch waits for the return pulse. It moves DS_IDLE→DS_OFFER when any line is pending. It moves DS_OFFER→DS_BUSY on a handshake when the handler address is even. It moves DS_OFFER→DS_IDLE on a handshake when the address is odd, which marks a handler that needs no return. It moves DS_BUSY→DS_IDLE on a return pulse.

A second machine tracks whether the core is running. `PS_RUN` moves to `PS_HALT` on a halt request. `PS_HALT` moves back to `PS_RUN` on a wake pulse or on a completed dispatch handshake.

Top module: `prio_irq_wake`

## Requirements
- R1: After reset the control word is zero and no line is enabled. `disp_valid`, `wake_o` and `core_halted` are all 0. An edge on any line after reset leads to no dispatch.
- R2: A write with `cfg_addr` 0..7 loads the handler address of that line. A write with `cfg_addr` 8 loads the control word: bits 7:0 are the enables and bits 15:8 are the wake-up marks for lines 0..7, and bits 31:16 are ignored. `disp_vector` is the address stored for `disp_index`.
- R3: A request is recorded only when a line goes from 0 to 1 between two clock samples. A line held high gives a single request, and a falling line gives none.
- R4: When several lines are pending, the lowest index is offered first.
- R5: An edge that arrives while its line is disabled is lost. Enabling the line afterwards does not dispatch it.
- R6: Once `disp_valid` rises, it stays high with `disp_index` and `disp_vector` unchanged until `disp_ready` is sampled high.
- R7: After a handshake with an even handler address, nothing more is offered until `ret_pulse`. Edges that arrive in that window are kept and are offered after the return.
- R8: After a handshake with an odd handler address, dispatch resumes at once, without any `ret_pulse`.
- R9: An enabled line with its wake-up mark set never becomes pending and never dispatches. Its edge gives a one-cycle `wake_o` pulse in the cycle after the edge.
- R10: `halt_req` sets `core_halted` on the next clock. `wake_o` or a completed handshake clears it on the next clock. A `wake_o` that is high in the same cycle as `halt_req` keeps the core running. `wake_o` has no effect while the core is running.
- R11: Wake-up edges release a halted core even while a handler for another line is running.
- R12: If the winning line rises again in the cycle of its handshake, it becomes pending again and is offered again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| irq_i | input | 8 | Request lines, already synchronous to clk |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 4 | 0..7 handler address of that line, 8 control word |
| cfg_wdata | input | 32 | Configuration write data |
| disp_valid | output | 1 | An interrupt is offered to the core |
| disp_ready | input | 1 | The core accepts the offer |
| disp_index | output | 3 | Index of the offered line |
| disp_vector | output | 32 | Handler address of the offered line |
| ret_pulse | input | 1 | The handler has returned |
| halt_req | input | 1 | The core asks to halt |
| core_halted | output | 1 | 1 while the core is halted |
| wake_o | output | 1 | One-cycle pulse for a wake-up edge |

## Verification
The assertions check several properties on every cycle:
- an offer stays stable until it is accepted;
- nothing is offered while a handler with an even address is running;
- the halt flag changes only through a halt request, a wake pulse or a handshake;
- the outputs clear after reset.

Only the bench scenarios can show the rest: which line wins a tie, that an edge on a disabled line is lost for good, that an edge taken during a handler is served after the return, and that a re-edge in the handshake cycle is kept. Each of these needs a chosen stimulus history and an expected line number worked out from it.

// File: rtl/prio_irq_pkg.sv
package prio_irq_pkg;
    localparam int NUM_IRQ = 8;
    localparam int DATA_W  = 32;

    typedef enum logic [1:0] {
        DS_IDLE  = 2'd0,
        DS_OFFER = 2'd1,
        DS_BUSY  = 2'd2
    } disp_state_t;

    typedef enum logic {
        PS_RUN  = 1'b0,
        PS_HALT = 1'b1
    } pwr_state_t;
endpackage

// File: rtl/prio_irq_cfg.sv
module prio_irq_cfg #(
    parameter int N      = 8,
    parameter int DW     = 32,
    parameter int IDX_W  = $clog2(N),
    parameter int ADDR_W = $clog2(N + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DW-1:0]     wdata,
    input  logic [IDX_W-1:0]  vec_sel,
    output logic [N-1:0]      en,
    output logic [N-1:0]      wk,
    output logic [DW-1:0]     vec_out
);
    localparam logic [ADDR_W-1:0] CTRL_ADDR = ADDR_W'(N);
    localparam logic [ADDR_W-1:0] VEC_LIMIT = ADDR_W'(N);

    logic [N-1:0]  en_q;
    logic [N-1:0]  wk_q;
    logic [DW-1:0] vec_q [N];
    logic          unused_rsvd;

    // Control bits above the two masks carry no meaning.
    assign unused_rsvd = ^wdata[DW-1:2*N];

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q <= '0;
            wk_q <= '0;
        end else if (we && addr == CTRL_ADDR) begin
            en_q <= wdata[N-1:0];
            wk_q <= wdata[2*N-1:N];
        end
    end

    for (genvar g = 0; g < N; g++) begin : g_vec
        always_ff @(posedge clk) begin
            if (rst) begin
                vec_q[g] <= '0;
            end else if (we && addr < VEC_LIMIT && addr[IDX_W-1:0] == IDX_W'(g)) begin
                vec_q[g] <= wdata;
            end
        end
    end

    assign en      = en_q;
    assign wk      = wk_q;
    assign vec_out = vec_q[vec_sel];
endmodule

// File: rtl/prio_irq_edge.sv
module prio_irq_edge #(
    parameter int N = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] irq,
    input  logic [N-1:0] en,
    input  logic [N-1:0] wk,
    input  logic [N-1:0] clr,
    output logic [N-1:0] pend,
    output logic         wake_hit
);
    logic [N-1:0] irq_q;
    logic [N-1:0] pend_q;
    logic [N-1:0] rise;

    assign rise = irq & ~irq_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            irq_q  <= '0;
            pend_q <= '0;
        end else begin
            irq_q  <= irq;
            // The clear comes first, so a fresh edge in the same cycle wins.
            // Lines that are disabled or marked for wake-up hold nothing.
            pend_q <= ((pend_q & ~clr) | rise) & en & ~wk;
        end
    end

    assign pend     = pend_q;
    assign wake_hit = |(rise & en & wk);
endmodule

// File: rtl/prio_irq_pick.sv
module prio_irq_pick #(
    parameter int N     = 8,
    parameter int IDX_W = $clog2(N)
) (
    input  logic [N-1:0]     req,
    output logic             any,
    output logic [IDX_W-1:0] idx
);
    logic [N-1:0] below;
    logic [N-1:0] grant;

    for (genvar g = 0; g < N; g++) begin : g_chain
        if (g == 0) begin : g_first
            assign below[g] = 1'b0;
        end else begin : g_rest
            assign below[g] = below[g-1] | req[g-1];
        end
        assign grant[g] = req[g] & ~below[g];
    end

    always_comb begin
        idx = '0;
        for (int i = 0; i < N; i++) begin
            if (grant[i]) begin
                idx = idx | IDX_W'(i);
            end
        end
    end

    assign any = |req;
endmodule

// File: rtl/prio_irq_wake.sv
module prio_irq_wake
    import prio_irq_pkg::*;
#(
    parameter int N      = NUM_IRQ,
    parameter int DW     = DATA_W,
    parameter int IDX_W  = $clog2(N),
    parameter int ADDR_W = $clog2(N + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [N-1:0]      irq_i,
    input  logic              cfg_we,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic [DW-1:0]     cfg_wdata,
    output logic              disp_valid,
    input  logic              disp_ready,
    output logic [IDX_W-1:0]  disp_index,
    output logic [DW-1:0]     disp_vector,
    input  logic              ret_pulse,
    input  logic              halt_req,
    output logic              core_halted,
    output logic              wake_o
);
    disp_state_t      ds_q, ds_d;
    pwr_state_t       ps_q, ps_d;
    logic [N-1:0]     en, wk, pend, clr;
    logic             wake_hit, wake_q;
    logic             pick_any;
    logic [IDX_W-1:0] pick_idx;
    logic [DW-1:0]    vec_out;
    logic [IDX_W-1:0] sel_idx_q;
    logic [DW-1:0]    sel_vec_q;
    logic             hs;

    prio_irq_cfg #(.N(N), .DW(DW), .IDX_W(IDX_W), .ADDR_W(ADDR_W)) u_cfg (
        .clk     (clk),
        .rst     (rst),
        .we      (cfg_we),
        .addr    (cfg_addr),
        .wdata   (cfg_wdata),
        .vec_sel (pick_idx),
        .en      (en),
        .wk      (wk),
        .vec_out (vec_out)
    );

    prio_irq_edge #(.N(N)) u_edge (
        .clk      (clk),
        .rst      (rst),
        .irq      (irq_i),
        .en       (en),
        .wk       (wk),
        .clr      (clr),
        .pend     (pend),
        .wake_hit (wake_hit)
    );

    prio_irq_pick #(.N(N), .IDX_W(IDX_W)) u_pick (
        .req (pend),
        .any (pick_any),
        .idx (pick_idx)
    );

    assign hs  = (ds_q == DS_OFFER) && disp_ready;
    assign clr = hs ? (N'(1) << sel_idx_q) : '0;

    // State and datapath registers
    always_ff @(posedge clk) begin
        if (rst) begin
            ds_q      <= DS_IDLE;
            ps_q      <= PS_RUN;
            wake_q    <= 1'b0;
            sel_idx_q <= '0;
            sel_vec_q <= '0;
        end else begin
            ds_q   <= ds_d;
            ps_q   <= ps_d;
            wake_q <= wake_hit;
            if (ds_q == DS_IDLE && pick_any) begin
                sel_idx_q <= pick_idx;
                sel_vec_q <= vec_out;
            end
        end
    end

    // Next-state logic for both machines
    always_comb begin
        ds_d = ds_q;
        unique case (ds_q)
            DS_IDLE:  if (pick_any)  ds_d = DS_OFFER;
            DS_OFFER: if (hs)        ds_d = sel_vec_q[0] ? DS_IDLE : DS_BUSY;
            DS_BUSY:  if (ret_pulse) ds_d = DS_IDLE;
            default:                 ds_d = DS_IDLE;
        endcase

        ps_d = ps_q;
        unique case (ps_q)
            PS_RUN:  if (halt_req && !wake_q) ps_d = PS_HALT;
            PS_HALT: if (wake_q || hs)        ps_d = PS_RUN;
            default:                          ps_d = PS_RUN;
        endcase
    end

    // Outputs
    always_comb begin
        disp_valid  = (ds_q == DS_OFFER);
        disp_index  = sel_idx_q;
        disp_vector = sel_vec_q;
        core_halted = (ps_q == PS_HALT);
        wake_o      = wake_q;
    end
endmodule

// File: rtl/prio_irq_wake_chk.sv
module prio_irq_wake_chk #(
    parameter int IDX_W = 3,
    parameter int DW    = 32
) (
    input logic             clk,
    input logic             rst,
    input logic             disp_valid,
    input logic             disp_ready,
    input logic [IDX_W-1:0] disp_index,
    input logic [DW-1:0]    disp_vector,
    input logic             ret_pulse,
    input logic             halt_req,
    input logic             core_halted,
    input logic             wake_o
);
    logic in_hdl;

    always_ff @(posedge clk) begin
        if (rst) begin
            in_hdl <= 1'b0;
        end else if (disp_valid && disp_ready) begin
            in_hdl <= !disp_vector[0];
        end else if (ret_pulse) begin
            in_hdl <= 1'b0;
        end
    end

    a_r1_reset_outputs: assert property (@(posedge clk)
        rst |=> (!disp_valid && !core_halted && !wake_o));

    a_r6_offer_held: assert property (@(posedge clk) disable iff (rst)
        (disp_valid && !disp_ready) |=> (disp_valid && $stable(disp_index) && $stable(disp_vector)));

    a_r7_quiet_in_handler: assert property (@(posedge clk) disable iff (rst)
        in_hdl |-> !disp_valid);

    a_r10_wake_releases: assert property (@(posedge clk) disable iff (rst)
        (core_halted && wake_o) |=> !core_halted);

    a_r10_halt_kept: assert property (@(posedge clk) disable iff (rst)
        (core_halted && !wake_o && !(disp_valid && disp_ready)) |=> core_halted);

    a_r10_run_kept: assert property (@(posedge clk) disable iff (rst)
        (!core_halted && !halt_req) |=> !core_halted);
endmodule

bind prio_irq_wake prio_irq_wake_chk #(.IDX_W(IDX_W), .DW(DW)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .disp_valid  (disp_valid),
    .disp_ready  (disp_ready),
    .disp_index  (disp_index),
    .disp_vector (disp_vector),
    .ret_pulse   (ret_pulse),
    .halt_req    (halt_req),
    .core_halted (core_halted),
    .wake_o      (wake_o)
);

// File: tb/prio_irq_wake_tb.sv
`timescale 1ns/1ps
module prio_irq_wake_tb;
    localparam int CLK_NS = 20;
    localparam int NV     = 6;

    // Table columns: control word, request pattern, whether a dispatch is expected, expected line.
    localparam logic [15:0] TV_CTRL [NV] = '{16'h00FF, 16'h00FF, 16'h00F0, 16'h01FF, 16'h0000, 16'h0080};
    localparam logic [7:0]  TV_IRQ  [NV] = '{8'h0C,    8'h81,    8'h21,    8'h03,    8'hFF,    8'h80};
    localparam logic        TV_DISP [NV] = '{1'b1,     1'b1,     1'b1,     1'b1,     1'b0,     1'b1};
    localparam logic [2:0]  TV_IDX  [NV] = '{3'd2,     3'd0,     3'd5,     3'd1,     3'd0,     3'd7};

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  irq_i = '0;
    logic        cfg_we = 1'b0;
    logic [3:0]  cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic        disp_ready = 1'b0;
    logic        ret_pulse = 1'b0;
    logic        halt_req = 1'b0;
    logic        disp_valid, core_halted, wake_o;
    logic [2:0]  disp_index;
    logic [31:0] disp_vector;

    int  n_chk  = 0;
    int  n_fail = 0;
    bit  done   = 1'b0;
    bit  got;

    always #(CLK_NS/2) clk = ~clk;

    prio_irq_wake u_dut (
        .clk(clk), .rst(rst), .irq_i(irq_i), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .disp_valid(disp_valid), .disp_ready(disp_ready),
        .disp_index(disp_index), .disp_vector(disp_vector), .ret_pulse(ret_pulse),
        .halt_req(halt_req), .core_halted(core_halted), .wake_o(wake_o)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk); rst = 1'b1; irq_i = '0; disp_ready = 1'b0; ret_pulse = 1'b0; halt_req = 1'b0;
        @(negedge clk); @(negedge clk); rst = 1'b0;
    endtask

    task automatic cfg_write(input logic [3:0] a, input logic [31:0] d);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk); cfg_we = 1'b0;
    endtask

    task automatic load_vectors(input logic [31:0] odd_mask);
        for (int i = 0; i < 8; i++) cfg_write(4'(i), 32'h1000 + 32'(i) * 32'h10 + 32'(odd_mask[i]));
    endtask

    task automatic pulse_irq(input logic [7:0] m);
        irq_i = m;
        @(negedge clk); irq_i = '0;
    endtask

    task automatic wait_valid(input int maxc, output bit found);
        found = 1'b0;
        for (int i = 0; i < maxc; i++) begin
            if (disp_valid) begin found = 1'b1; break; end
            @(negedge clk);
        end
    endtask

    task automatic accept();
        disp_ready = 1'b1;
        @(negedge clk); disp_ready = 1'b0;
    endtask

    task automatic give_ret();
        ret_pulse = 1'b1;
        @(negedge clk); ret_pulse = 1'b0;
    endtask

    task automatic pulse_halt();
        halt_req = 1'b1;
        @(negedge clk); halt_req = 1'b0;
    endtask

    task automatic summary();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    initial begin
        #(CLK_NS * 200000);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
        summary();
    end

    initial begin
        // R1: reset state, nothing enabled
        do_reset();
        check(!disp_valid && !core_halted && !wake_o, "R1 reset outputs",
              {29'd0, disp_valid, core_halted, wake_o}, 0);
        pulse_irq(8'hFF);
        wait_valid(8, got);
        check(!got, "R1 no dispatch with zero control", 32'(got), 0);

        // Table walk: R2 vector lookup and R4 priority; R5 and R9 rows included
        for (int v = 0; v < NV; v++) begin
            do_reset();
            load_vectors(0);
            cfg_write(4'd8, {16'hFFFF, TV_CTRL[v]});
            pulse_irq(TV_IRQ[v]);
            wait_valid(8, got);
            check(got == TV_DISP[v], "R4 dispatch expected", 32'(got), 32'(TV_DISP[v]));
            if (got && TV_DISP[v]) begin
                check(disp_index == TV_IDX[v], "R4 winning line", 32'(disp_index), 32'(TV_IDX[v]));
                check(disp_vector == 32'h1000 + 32'(TV_IDX[v]) * 32'h10, "R2 vector for line",
                      disp_vector, 32'h1000 + 32'(TV_IDX[v]) * 32'h10);
                accept();
                give_ret();
            end
        end

        // R3: held high gives one request; a fall gives none
        do_reset(); load_vectors(0); cfg_write(4'd8, 32'h0001);
        irq_i = 8'h01;
        @(negedge clk);
        wait_valid(8, got);
        check(got, "R3 rise dispatches", 32'(got), 1);
        accept(); give_ret();
        wait_valid(8, got);
        check(!got, "R3 level held no repeat", 32'(got), 0);
        irq_i = 8'h00;
        @(negedge clk);
        wait_valid(8, got);
        check(!got, "R3 fall ignored", 32'(got), 0);

        // R5: edge while disabled is lost after enabling
        do_reset(); load_vectors(0);
        pulse_irq(8'h08);
        cfg_write(4'd8, 32'h0008);
        wait_valid(8, got);
        check(!got, "R5 disabled edge lost", 32'(got), 0);
        pulse_irq(8'h08);
        wait_valid(8, got);
        check(got && disp_index == 3'd3, "R5 later edge served", 32'(disp_index), 3);

        // R6: offer held while ready low
        repeat (3) @(negedge clk);
        check(disp_valid && disp_index == 3'd3 && disp_vector == 32'h1030, "R6 offer held",
              disp_vector, 32'h1030);
        accept(); give_ret();

        // R7: no dispatch inside handler; edge kept for after return
        do_reset(); load_vectors(0); cfg_write(4'd8, 32'h0003);
        pulse_irq(8'h02);
        wait_valid(8, got); accept();
        pulse_irq(8'h01);
        wait_valid(8, got);
        check(!got, "R7 quiet in handler", 32'(got), 0);
        give_ret();
        wait_valid(8, got);
        check(got && disp_index == 3'd0, "R7 served after return", 32'(disp_index), 0);

        // R8: odd vector needs no return
        do_reset(); load_vectors(32'h04); cfg_write(4'd8, 32'h0004);
        pulse_irq(8'h04);
        wait_valid(8, got); accept();
        pulse_irq(8'h04);
        wait_valid(8, got);
        check(got && disp_index == 3'd2, "R8 no return needed", 32'(got), 1);

        // R12: re-edge in the handshake cycle re-pends
        do_reset(); load_vectors(32'h01); cfg_write(4'd8, 32'h0001);
        pulse_irq(8'h01);
        wait_valid(8, got);
        disp_ready = 1'b1; irq_i = 8'h01;
        @(negedge clk); disp_ready = 1'b0; irq_i = 8'h00;
        wait_valid(8, got);
        check(got && disp_index == 3'd0, "R12 re-pended", 32'(got), 1);

        // R9: wake line pulses once and never dispatches
        do_reset(); load_vectors(0); cfg_write(4'd8, 32'h0101);
        pulse_irq(8'h01);
        check(wake_o, "R9 wake pulse", 32'(wake_o), 1);
        @(negedge clk);
        check(!wake_o, "R9 pulse one cycle", 32'(wake_o), 0);
        wait_valid(8, got);
        check(!got, "R9 no dispatch", 32'(got), 0);

        // R10: wake while running has no effect; halt; wake releases
        pulse_irq(8'h01); @(negedge clk);
        check(!core_halted, "R10 wake while running", 32'(core_halted), 0);
        pulse_halt();
        repeat (3) @(negedge clk);
        check(core_halted, "R10 halted", 32'(core_halted), 1);
        pulse_irq(8'h01);
        @(negedge clk);
        check(!core_halted, "R10 wake releases", 32'(core_halted), 0);
        pulse_irq(8'h01);
        pulse_halt();
        check(!core_halted, "R10 same-cycle wake keeps running", 32'(core_halted), 0);

        // R10: a completed handshake releases the halt
        do_reset(); load_vectors(0); cfg_write(4'd8, 32'h0010);
        pulse_halt();
        pulse_irq(8'h10);
        wait_valid(8, got);
        check(core_halted, "R10 halted until handshake", 32'(core_halted), 1);
        accept();
        check(!core_halted, "R10 dispatch releases", 32'(core_halted), 0);

        // R11: wake line acts inside a handler
        do_reset(); load_vectors(0); cfg_write(4'd8, 32'h0203);
        pulse_irq(8'h01);
        wait_valid(8, got); accept();
        pulse_halt();
        check(core_halted, "R11 halted in handler", 32'(core_halted), 1);
        pulse_irq(8'h02);
        @(negedge clk);
        check(!core_halted, "R11 wake inside handler", 32'(core_halted), 0);

        summary();
    end
endmodule